// File: doc/BRIEF.md
# Receive Carrier Sense Hold Timer

This block derives an internal carrier-sense flag from activity on a serial receive data line. It synchronizes the raw data input and compares each synchronized sample with the one before it. Any difference counts as a transition. A transition reloads a hold counter and asserts carrier sense. The counter then counts down on a bit-rate strobe. When it runs out with no new transition, carrier sense drops. A steady run of transitions, such as a synchronization preamble ahead of an opening flag, therefore keeps carrier present the whole time.

A 2-bit hold-mode input selects the hold length. A divider-nonzero input chooses between two strobe meanings. When the divider is zero, the strobe marks whole bits. When it is nonzero, the strobe arrives at twice the bit rate, so hold lengths can end on a half bit. Hold mode 0 forces carrier permanently present. This is the mode that applies after reset. On every carrier-sense edge the block emits a one-cycle change pulse, which an interrupt controller can latch. The clock recovery logic and the divider itself are outside this block.

Top module: `cs_hold_timer`

## Requirements
- R1: After reset, carrier_o is 1 and carrier_chg_o is 0.
- R2: While hold_mode_i is 0, carrier_o is 1 from the next cycle on, whatever ticks or transitions arrive, and carrier_chg_o stays 0.
- R3: A level change on rxd_i shows as carrier_o = 1 at the third rising clock edge after the change, and not before (two synchronizer stages plus the compare register).
- R4: With hold_mode_i = 1, carrier stays up for 14 strobes after the last transition when div_nz_i = 0, and for 13 strobes (6.5 bits at half-bit strobes) when div_nz_i = 1. It drops on the edge that takes the last strobe.
- R5: With hold_mode_i = 2, the hold is 4 strobes when div_nz_i = 0 and 5 strobes (2.5 bits) when div_nz_i = 1.
- R6: With hold_mode_i = 3, the hold is 3 strobes when div_nz_i = 0 and 2 strobes (1 bit) when div_nz_i = 1.
- R7: A transition during a running hold reloads the full hold count, so the hold is measured from the most recent transition.
- R8: carrier_chg_o is high for exactly one cycle, in the same cycle carrier_o first shows its new value, on both rising and falling edges of carrier_o.
- R9: Changing hold_mode_i between nonzero codes does not shorten a hold that is already running. The new length applies from the next transition.
- R10: On leaving hold mode 0 with no hold running, carrier_o stays 1 until the first strobe, which clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rxd_i | input | 1 | Raw serial receive data |
| bit_tick_i | input | 1 | One-cycle strobe: once per bit (divider zero) or twice per bit (divider nonzero) |
| div_nz_i | input | 1 | Receive clock divider is nonzero (oversampled clocking) |
| hold_mode_i | input | 2 | Hold-length select; 0 means carrier always present |
| carrier_o | output | 1 | Internal carrier-sense flag |
| carrier_chg_o | output | 1 | One-cycle pulse on each carrier-sense edge |

## Verification
The bench builds the block with its default parameters. Two synchronizer stages put the rise of carrier sense three edges after a data change. A 4-bit counter with the default hold table can reach the longest hold of 14 strobes. With these values, all six mode and divider hold lengths can be checked strobe by strobe at their last-strobe boundary. The same setting covers a reload in mid-hold, a mode change during a long hold, and the exit from the always-present mode.

// File: rtl/cs_hold_pkg.sv
package cs_hold_pkg;

  typedef enum logic [1:0] {
    CS_ALWAYS = 2'd0,
    CS_LONG   = 2'd1,
    CS_NORMAL = 2'd2,
    CS_SHORT  = 2'd3
  } cs_mode_e;

endpackage

// File: rtl/cs_edge_detect.sv
module cs_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd_i,
  output logic trans_o
);

  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q, sync_d;
  logic         prev_q, prev_d;

  // Next-state: shift raw data in, keep the last synchronized sample.
  always_comb begin
    sync_d = {sync_q[MSB-1:0], rxd_i};
    prev_d = sync_q[MSB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign trans_o = sync_q[MSB] ^ prev_q;

endmodule

// File: rtl/cs_hold_counter.sv
module cs_hold_counter
  import cs_hold_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int HOLD_1X_L = 14,
  parameter int HOLD_1X_N = 4,
  parameter int HOLD_1X_S = 3,
  parameter int HOLD_OS_L = 13,
  parameter int HOLD_OS_N = 5,
  parameter int HOLD_OS_S = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trans_i,
  input  logic       tick_i,
  input  logic       div_nz_i,
  input  cs_mode_e   mode_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic       expire_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d, hold_len;
  logic             cnt_en;

  // Hold length in strobe units; oversampled mode counts half bits.
  always_comb begin
    unique case (mode_i)
      CS_LONG:   hold_len = div_nz_i ? CNT_W'(HOLD_OS_L) : CNT_W'(HOLD_1X_L);
      CS_NORMAL: hold_len = div_nz_i ? CNT_W'(HOLD_OS_N) : CNT_W'(HOLD_1X_N);
      CS_SHORT:  hold_len = div_nz_i ? CNT_W'(HOLD_OS_S) : CNT_W'(HOLD_1X_S);
      default:   hold_len = '0;
    endcase
  end

  always_comb begin
    cnt_en = trans_i | (tick_i & (cnt_q != '0));
    cnt_d  = trans_i ? hold_len : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o    = cnt_q;
  assign expire_o = ~trans_i & tick_i & (cnt_q <= CNT_W'(1));

endmodule

// File: rtl/cs_sense_flag.sv
module cs_sense_flag
  import cs_hold_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  cs_mode_e mode_i,
  input  logic     trans_i,
  input  logic     expire_i,
  output logic     carrier_o,
  output logic     chg_o
);

  logic carrier_q, carrier_d;
  logic chg_q, chg_d;

  always_comb begin
    if (mode_i == CS_ALWAYS) carrier_d = 1'b1;
    else if (trans_i)        carrier_d = 1'b1;
    else if (expire_i)       carrier_d = 1'b0;
    else                     carrier_d = carrier_q;
    chg_d = (mode_i != CS_ALWAYS) & (carrier_d ^ carrier_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carrier_q <= 1'b1;
      chg_q     <= 1'b0;
    end else begin
      carrier_q <= carrier_d;
      chg_q     <= chg_d;
    end
  end

  assign carrier_o = carrier_q;
  assign chg_o     = chg_q;

endmodule

// File: rtl/cs_hold_timer.sv
module cs_hold_timer
  import cs_hold_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 4,
  parameter int HOLD_1X_L   = 14,
  parameter int HOLD_1X_N   = 4,
  parameter int HOLD_1X_S   = 3,
  parameter int HOLD_OS_L   = 13,
  parameter int HOLD_OS_N   = 5,
  parameter int HOLD_OS_S   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd_i,
  input  logic       bit_tick_i,
  input  logic       div_nz_i,
  input  logic [1:0] hold_mode_i,
  output logic       carrier_o,
  output logic       carrier_chg_o
);

  localparam int HOLD_MAX = HOLD_1X_L > HOLD_OS_L ? HOLD_1X_L : HOLD_OS_L;

  cs_mode_e         mode_w;
  logic             trans_w;
  logic             expire_w;
  logic [CNT_W-1:0] cnt_w;

  assign mode_w = cs_mode_e'(hold_mode_i);

  cs_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .rxd_i   (rxd_i),
    .trans_o (trans_w)
  );

  cs_hold_counter #(
    .CNT_W(CNT_W),
    .HOLD_1X_L(HOLD_1X_L), .HOLD_1X_N(HOLD_1X_N), .HOLD_1X_S(HOLD_1X_S),
    .HOLD_OS_L(HOLD_OS_L), .HOLD_OS_N(HOLD_OS_N), .HOLD_OS_S(HOLD_OS_S)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .trans_i  (trans_w),
    .tick_i   (bit_tick_i),
    .div_nz_i (div_nz_i),
    .mode_i   (mode_w),
    .cnt_o    (cnt_w),
    .expire_o (expire_w)
  );

  cs_sense_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_w),
    .trans_i   (trans_w),
    .expire_i  (expire_w),
    .carrier_o (carrier_o),
    .chg_o     (carrier_chg_o)
  );

endmodule

// File: rtl/cs_hold_timer_chk.sv
module cs_hold_timer_chk #(
  parameter int CNT_W    = 4,
  parameter int MAX_HOLD = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       hold_mode_i,
  input logic             bit_tick_i,
  input logic             trans_w,
  input logic             carrier_o,
  input logic             carrier_chg_o,
  input logic [CNT_W-1:0] cnt_w
);

  // R2
  always_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_mode_i == 2'd0) |=> carrier_o);

  // R2
  no_pulse_in_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_mode_i == 2'd0) |=> !carrier_chg_o);

  // R8
  pulse_matches_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carrier_chg_o |-> (carrier_o != $past(carrier_o)));

  // R8
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carrier_chg_o |=> !carrier_chg_o);

  // R4
  drop_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(carrier_o) |-> ($past(bit_tick_i) && !$past(trans_w)));

  // R7
  transition_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trans_w |=> carrier_o);

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_w <= CNT_W'(MAX_HOLD));

endmodule

bind cs_hold_timer cs_hold_timer_chk #(.CNT_W(CNT_W), .MAX_HOLD(HOLD_MAX)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .hold_mode_i   (hold_mode_i),
  .bit_tick_i    (bit_tick_i),
  .trans_w       (trans_w),
  .carrier_o     (carrier_o),
  .carrier_chg_o (carrier_chg_o),
  .cnt_w         (cnt_w)
);

// File: tb/cs_hold_timer_bench.sv
module cs_hold_timer_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b0;
  logic       tick = 1'b0;
  logic       div_nz = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       carrier, chg;
  int         checks = 0;
  int         errors = 0;

  always #4 clk = ~clk;

  cs_hold_timer u_cs_hold_timer (
    .clk           (clk),
    .rst_n         (rst_n),
    .rxd_i         (rxd),
    .bit_tick_i    (tick),
    .div_nz_i      (div_nz),
    .hold_mode_i   (mode),
    .carrier_o     (carrier),
    .carrier_chg_o (chg)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  // Toggle data and wait for carrier to rise (3 edges).
  task automatic toggle_and_rise(input string req);
    rxd = ~rxd;
    repeat (2) @(negedge clk);
    chk("R3", {req, " not yet up"}, carrier, 1'b0);
    @(negedge clk);
    chk("R3", {req, " up"}, carrier, 1'b1);
    chk("R8", {req, " rise pulse"}, chg, 1'b1);
    @(negedge clk);
    chk("R8", {req, " rise pulse ends"}, chg, 1'b0);
  endtask

  task automatic enter_mode(input logic [1:0] m, input logic d);
    mode = m; div_nz = d;
    @(negedge clk);
    chk("R10", "kept until strobe", carrier, 1'b1);
    pulse_tick();
    chk("R10", "cleared by first strobe", carrier, 1'b0);
    chk("R8", "fall pulse", chg, 1'b1);
    @(negedge clk);
  endtask

  task automatic back_to_always();
    mode = 2'd0;
    @(negedge clk);
    chk("R2", "forced up", carrier, 1'b1);
    chk("R2", "no pulse", chg, 1'b0);
  endtask

  task automatic test_reset();
    chk("R1", "carrier at reset", carrier, 1'b1);
    chk("R1", "pulse at reset", chg, 1'b0);
  endtask

  task automatic test_always();
    for (int i = 0; i < 6; i++) begin
      if (i % 2 == 0) rxd = ~rxd;
      pulse_tick();
      chk("R2", "carrier stays", carrier, 1'b1);
      chk("R2", "no pulse", chg, 1'b0);
    end
    repeat (4) @(negedge clk);
    chk("R2", "carrier after settle", carrier, 1'b1);
  endtask

  task automatic test_hold(input logic [1:0] m, input logic d, input int h, input string req);
    enter_mode(m, d);
    toggle_and_rise(req);
    for (int i = 0; i < h - 1; i++) pulse_tick();
    chk(req, "held before last strobe", carrier, 1'b1);
    pulse_tick();
    chk(req, "dropped on last strobe", carrier, 1'b0);
    chk("R8", "fall pulse", chg, 1'b1);
    @(negedge clk);
    chk("R8", "fall pulse ends", chg, 1'b0);
    back_to_always();
  endtask

  task automatic test_retrigger();
    enter_mode(2'd2, 1'b0);
    toggle_and_rise("R7");
    for (int i = 0; i < 3; i++) pulse_tick();
    chk("R7", "still up before reload", carrier, 1'b1);
    rxd = ~rxd;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 3; i++) pulse_tick();
    chk("R7", "reloaded hold still up", carrier, 1'b1);
    pulse_tick();
    chk("R7", "drop after full reload", carrier, 1'b0);
    back_to_always();
  endtask

  task automatic test_mode_change();
    enter_mode(2'd1, 1'b0);
    toggle_and_rise("R9");
    mode = 2'd3;
    for (int i = 0; i < 3; i++) pulse_tick();
    chk("R9", "not truncated by short mode", carrier, 1'b1);
    for (int i = 0; i < 10; i++) pulse_tick();
    chk("R9", "still up at 13 strobes", carrier, 1'b1);
    pulse_tick();
    chk("R9", "drop at original 14", carrier, 1'b0);
    back_to_always();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_always();
    test_hold(2'd1, 1'b0, 14, "R4");
    test_hold(2'd1, 1'b1, 13, "R4");
    test_hold(2'd2, 1'b0, 4, "R5");
    test_hold(2'd2, 1'b1, 5, "R5");
    test_hold(2'd3, 1'b0, 3, "R6");
    test_hold(2'd3, 1'b1, 2, "R6");
    test_retrigger();
    test_mode_change();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule